// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Logic

This block watches the signals of one or more removable-card sockets and turns their level changes into latched events and an interrupt request. Each socket has two card-detect pins, two battery-voltage pins, a ready pin, a write-protect pin and a power-applied pin. All of them are synchronized inside the block. A live status register shows their current levels. The battery-voltage and status-change levels are active low, so a 0 means the condition is asserted. A change register latches events. Each socket has a per-socket enable mask, and the socket raises its interrupt request while any enabled event stays latched. The requests of all sockets are ORed into a single interrupt line.

Software reaches the registers through a simple register port. It selects a socket and a register address and pulses a read or a write. Read data appears on the clock after the read. Reading the change register returns the latched events and clears them. A dummy read therefore discards stale events. A mode bit per socket selects memory-card or I/O-card meaning. In I/O-card mode, battery pin 1 is a card status-change signal, and the battery pin 2 and ready events are not recorded.

A small controller has two states. It holds event detection off while the synchronizer pipeline fills after reset. In ST_FILL, a counter runs for SYNC_STAGES+1 clocks. The transition FILL_DONE moves to ST_RUN when the counter reaches its last value. ST_RUN holds with the transition STAY_RUN until reset. Only ST_RUN enables edge recording.

Top module: `card_event_irq`

## Requirements
- R1: After reset, the change, enable and mode registers are 0, all interrupt outputs are 0 and the read data is 0. Pin levels present during reset and during the pipeline fill (ST_FILL) record no event.
- R2: Register address 1 is the status register. Its bit 0 is battery pin 1, bit 1 is battery pin 2, bit 2 is detect A, bit 3 is detect B, bit 4 is write-protect, bit 5 is ready, bit 6 is power, and bit 7 reads 0. A pin level sampled at clock k shows in a status read issued at clock k+2 or later.
- R3: Change bit 3 (detect) sets only when the card-present signal (detect A AND detect B) changes. A toggle of one detect pin while the other is 0 records nothing.
- R4: In memory-card mode (mode bit 0 = 0), any edge on battery pin 1, battery pin 2 or ready sets change bit 0, 1 or 2 respectively.
- R5: In I/O-card mode (mode bit 0 = 1), an edge on battery pin 1 sets change bit 0. Edges on battery pin 2 and ready set nothing.
- R6: A read of the change register (address 4) returns the latched bits in bits 3:0 and clears them, so an immediate second read returns 0.
- R7: An event whose edge is recorded on the same clock as a clearing read is not returned by that read and stays latched.
- R8: A socket's interrupt request is 1 exactly while some latched change bit has its enable bit set, and it stays held until cleared or disabled. The top-level interrupt is the OR of the socket requests.
- R9: Address 3 holds the mode bit in bit 0 and address 5 holds the four enable bits in bits 3:0. Both read back what was written, with the other bits reading 0. Writes to addresses 1 and 4 have no effect. Read data is 0 on clocks that follow no read.
- R10: Sockets are independent: events and register accesses of one socket never change another socket's registers or request.
- R11: Edges on write-protect and power are visible in the status register but set no change bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| card_det_a | input | NSOCK | Detect pin A per socket |
| card_det_b | input | NSOCK | Detect pin B per socket |
| card_bvd1 | input | NSOCK | Battery pin 1 / status-change per socket (active low) |
| card_bvd2 | input | NSOCK | Battery pin 2 per socket (active low) |
| card_rdy | input | NSOCK | Ready (not busy) per socket |
| card_wp | input | NSOCK | Write-protect per socket |
| card_pwr | input | NSOCK | Power-applied per socket |
| reg_sel | input | SEL_W | Socket selected for the access |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the clock after reg_rd |
| irq_sock | output | NSOCK | Per-socket interrupt request |
| irq | output | 1 | OR of all socket requests |

## Verification
A pin level sampled at clock k passes the two synchronizer flops, and the edge is compared at clock k+2. From there:

- The change bit and the interrupt request change right after clock k+2.
- A status read issued at k+2 returns the new level.
- Read data and register writes take effect on the clock of the strobe and are observed half a period later.

The bench model keeps a history of sampled pin words per socket and derives every one of these results at the same clock. It compares the read data and all interrupt outputs at each falling edge. The coincident-read case is placed exactly on clock k+2.

// File: rtl/card_event_pkg.sv
package card_event_pkg;
    localparam int REG_AW   = 3;
    localparam int PIN_W    = 7;
    localparam int CHG_W    = 4;

    localparam logic [REG_AW-1:0] ADDR_STATUS = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_MODE   = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_CHG    = 3'd4;
    localparam logic [REG_AW-1:0] ADDR_ENA    = 3'd5;

    localparam int CHG_BAT1 = 0;
    localparam int CHG_BAT2 = 1;
    localparam int CHG_RDY  = 2;
    localparam int CHG_DET  = 3;

    typedef struct packed {
        logic pwr;
        logic rdy;
        logic wp;
        logic det_b;
        logic det_a;
        logic bat2;
        logic bat1;
    } pins_t;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/card_event_sync.sv
module card_event_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= '0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/card_event_socket.sv
module card_event_socket
    import card_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             detect_en,
    input  pins_t            pins,
    input  logic             mode_wr,
    input  logic             ena_wr,
    input  logic [7:0]       wdata,
    input  logic             chg_clr,
    output logic [7:0]       status_o,
    output logic             io_mode_o,
    output logic [CHG_W-1:0] ena_o,
    output logic [CHG_W-1:0] chg_o,
    output logic [CHG_W-1:0] set_o,
    output logic             irq_o
);
    pins_t            prev_q;
    logic             io_q;
    logic [CHG_W-1:0] ena_q;
    logic [CHG_W-1:0] chg_q;
    logic [CHG_W-1:0] set_v;
    logic             present_now;
    logic             present_old;

    assign present_now = pins.det_a & pins.det_b;
    assign present_old = prev_q.det_a & prev_q.det_b;

    always_comb begin
        set_v = '0;
        if (detect_en) begin
            set_v[CHG_BAT1] = pins.bat1 ^ prev_q.bat1;
            set_v[CHG_BAT2] = !io_q && (pins.bat2 ^ prev_q.bat2);
            set_v[CHG_RDY]  = !io_q && (pins.rdy ^ prev_q.rdy);
            set_v[CHG_DET]  = present_now ^ present_old;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            io_q   <= 1'b0;
            ena_q  <= '0;
            chg_q  <= '0;
        end else begin
            prev_q <= pins;
            if (mode_wr) io_q  <= wdata[0];
            if (ena_wr)  ena_q <= wdata[CHG_W-1:0];
            chg_q <= (chg_clr ? '0 : chg_q) | set_v;
        end
    end

    assign status_o  = {1'b0, pins};
    assign io_mode_o = io_q;
    assign ena_o     = ena_q;
    assign chg_o     = chg_q;
    assign set_o     = set_v;
    assign irq_o     = |(chg_q & ena_q);
endmodule

// File: rtl/card_event_irq.sv
module card_event_irq
    import card_event_pkg::*;
#(
    parameter int NSOCK       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSOCK-1:0]  card_det_a,
    input  logic [NSOCK-1:0]  card_det_b,
    input  logic [NSOCK-1:0]  card_bvd1,
    input  logic [NSOCK-1:0]  card_bvd2,
    input  logic [NSOCK-1:0]  card_rdy,
    input  logic [NSOCK-1:0]  card_wp,
    input  logic [NSOCK-1:0]  card_pwr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [2:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NSOCK-1:0]  irq_sock,
    output logic              irq
);
    localparam int FILL_LEN = SYNC_STAGES + 1;
    localparam int CNT_W    = $clog2(FILL_LEN + 1);
    localparam int RAW_W    = NSOCK * PIN_W;

    run_state_t       state, state_nx;
    logic [CNT_W-1:0] fill_cnt;
    logic             detect_en;

    logic [RAW_W-1:0] raw_pins;
    logic [RAW_W-1:0] sync_pins;

    logic [NSOCK-1:0][CHG_W-1:0] chg_a;
    logic [NSOCK-1:0][CHG_W-1:0] set_a;
    logic [NSOCK-1:0][CHG_W-1:0] ena_a;
    logic [NSOCK-1:0][7:0]       stat_a;
    logic [NSOCK-1:0]            io_v;
    logic [NSOCK-1:0]            clr_v;
    logic [NSOCK-1:0]            mode_wr_v;
    logic [NSOCK-1:0]            ena_wr_v;
    logic [7:0]                  rd_mux;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: if (fill_cnt == CNT_W'(FILL_LEN - 1)) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    // state outputs
    always_comb begin
        detect_en = 1'b0;
        unique case (state)
            ST_FILL: detect_en = 1'b0;
            ST_RUN:  detect_en = 1'b1;
        endcase
    end

    for (genvar s = 0; s < NSOCK; s++) begin : g_pack
        assign raw_pins[s*PIN_W +: PIN_W] = {card_pwr[s], card_rdy[s], card_wp[s],
                                             card_det_b[s], card_det_a[s],
                                             card_bvd2[s], card_bvd1[s]};
    end

    card_event_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_pins),
        .q    (sync_pins)
    );

    for (genvar s = 0; s < NSOCK; s++) begin : g_sock
        logic hit;
        assign hit          = (reg_sel == SEL_W'(s));
        assign mode_wr_v[s] = reg_wr && hit && (reg_addr == ADDR_MODE);
        assign ena_wr_v[s]  = reg_wr && hit && (reg_addr == ADDR_ENA);
        assign clr_v[s]     = reg_rd && hit && (reg_addr == ADDR_CHG);

        card_event_socket u_sock (
            .clk      (clk),
            .rst_n    (rst_n),
            .detect_en(detect_en),
            .pins     (pins_t'(sync_pins[s*PIN_W +: PIN_W])),
            .mode_wr  (mode_wr_v[s]),
            .ena_wr   (ena_wr_v[s]),
            .wdata    (reg_wdata),
            .chg_clr  (clr_v[s]),
            .status_o (stat_a[s]),
            .io_mode_o(io_v[s]),
            .ena_o    (ena_a[s]),
            .chg_o    (chg_a[s]),
            .set_o    (set_a[s]),
            .irq_o    (irq_sock[s])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int s = 0; s < NSOCK; s++) begin
            if (reg_sel == SEL_W'(s)) begin
                unique case (reg_addr)
                    ADDR_STATUS: rd_mux = stat_a[s];
                    ADDR_MODE:   rd_mux = {7'd0, io_v[s]};
                    ADDR_CHG:    rd_mux = {{(8-CHG_W){1'b0}}, chg_a[s]};
                    ADDR_ENA:    rd_mux = {{(8-CHG_W){1'b0}}, ena_a[s]};
                    default:     rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
        else             reg_rdata <= '0;
    end

    assign irq = |irq_sock;
endmodule

// File: rtl/card_event_irq_chk.sv
module card_event_irq_chk #(
    parameter int NSOCK = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic                  reg_rd,
    input logic [7:0]            reg_rdata,
    input logic [NSOCK-1:0][3:0] chg,
    input logic [NSOCK-1:0][3:0] set,
    input logic [NSOCK-1:0]      clr,
    input logic [NSOCK-1:0]      io,
    input logic [NSOCK-1:0]      ena_wr,
    input logic [NSOCK-1:0]      irq_sock
);
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> reg_rdata == 8'd0); // R9

    for (genvar s = 0; s < NSOCK; s++) begin : g_chk
        AST_QUIET_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            !run |-> chg[s] == 4'd0); // R1
        AST_CLEAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[s] && set[s] == 4'd0) |=> chg[s] == 4'd0); // R6
        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set[s][0] && clr[s]) |=> chg[s][0]); // R7
        AST_IO_NO_BAT2: assert property (@(posedge clk) disable iff (!rst_n)
            (io[s] && !chg[s][1]) |=> !chg[s][1]); // R5
        AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_sock[s] && !clr[s] && !ena_wr[s]) |=> irq_sock[s]); // R8
    end
endmodule

bind card_event_irq card_event_irq_chk #(.NSOCK(NSOCK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (detect_en),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata),
    .chg      (chg_a),
    .set      (set_a),
    .clr      (clr_v),
    .io       (io_v),
    .ena_wr   (ena_wr_v),
    .irq_sock (irq_sock)
);

// File: tb/sim_card_event_irq.sv
module sim_card_event_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pin_v [2];
    logic [0:0] reg_sel = '0;
    logic [2:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] irq_sock;
    logic       irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // model state
    logic [6:0] hist [2][$];
    logic [3:0] chg_m [2];
    logic [3:0] ena_m [2];
    logic       io_m  [2];
    logic [7:0] rdata_m;
    logic [1:0] irq_m;

    always #2 clk = ~clk;

    card_event_irq u0 (
        .clk(clk), .rst_n(rst_n),
        .card_det_a({pin_v[1][2], pin_v[0][2]}),
        .card_det_b({pin_v[1][3], pin_v[0][3]}),
        .card_bvd1 ({pin_v[1][0], pin_v[0][0]}),
        .card_bvd2 ({pin_v[1][1], pin_v[0][1]}),
        .card_rdy  ({pin_v[1][5], pin_v[0][5]}),
        .card_wp   ({pin_v[1][4], pin_v[0][4]}),
        .card_pwr  ({pin_v[1][6], pin_v[0][6]}),
        .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_sock(irq_sock), .irq(irq)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0] rv;
        rv = 8'd0;
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                hist[s].delete();
                chg_m[s] = '0; ena_m[s] = '0; io_m[s] = 1'b0;
            end
            rdata_m = '0; irq_m = '0;
            return;
        end
        for (int s = 0; s < 2; s++) begin
            logic [6:0] stat, now, old;
            logic [3:0] setb;
            stat = (hist[s].size() >= 2) ? hist[s][1] : 7'd0;
            setb = '0;
            if (hist[s].size() == 3) begin
                now = hist[s][1]; old = hist[s][2];
                setb[0] = now[0] != old[0];
                setb[1] = !io_m[s] && (now[1] != old[1]);
                setb[2] = !io_m[s] && (now[5] != old[5]);
                setb[3] = (now[2] & now[3]) != (old[2] & old[3]);
            end
            if (reg_rd && reg_sel == 1'(s)) begin
                case (reg_addr)
                    3'd1: rv = {1'b0, stat};
                    3'd3: rv = {7'd0, io_m[s]};
                    3'd4: rv = {4'd0, chg_m[s]};
                    3'd5: rv = {4'd0, ena_m[s]};
                    default: rv = 8'd0;
                endcase
            end
            if (reg_rd && reg_sel == 1'(s) && reg_addr == 3'd4) chg_m[s] = '0;
            chg_m[s] = chg_m[s] | setb;
            if (reg_wr && reg_sel == 1'(s) && reg_addr == 3'd3) io_m[s] = reg_wdata[0];
            if (reg_wr && reg_sel == 1'(s) && reg_addr == 3'd5) ena_m[s] = reg_wdata[3:0];
            hist[s].push_front(pin_v[s]);
            if (hist[s].size() > 3) void'(hist[s].pop_back());
            irq_m[s] = |(chg_m[s] & ena_m[s]);
        end
        rdata_m = rv;
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        chk(irq_sock == irq_m, "irq_sock", irq_sock, irq_m);
        chk(irq == |irq_m, "irq", irq, |irq_m);
        chk(reg_rdata == rdata_m, "rdata", reg_rdata, rdata_m);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic rd(input int s, input int a, input int exp);
        reg_sel = 1'(s); reg_addr = 3'(a); reg_rd = 1'b1;
        cyc();
        reg_rd = 1'b0;
        chk(reg_rdata == 8'(exp), "read literal", reg_rdata, exp);
    endtask

    task automatic wr(input int s, input int a, input int d);
        reg_sel = 1'(s); reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pin_v[0] = 7'h6F;
        pin_v[1] = 7'h03;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        // R1: nothing recorded from reset-time levels
        cur_req = "R1"; idle(6);
        rd(0, 4, 8'h00); rd(1, 4, 8'h00);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        cur_req = "R2"; rd(0, 1, 8'h6F); rd(1, 1, 8'h03);
        cur_req = "R9";
        wr(0, 5, 8'hFF); rd(0, 5, 8'h0F);
        wr(0, 3, 8'hFF); rd(0, 3, 8'h01); wr(0, 3, 8'h00); rd(0, 3, 8'h00);
        wr(0, 1, 8'h55); rd(0, 1, 8'h6F);
        wr(0, 4, 8'h0F); rd(0, 4, 8'h00);
        cur_req = "R4";
        pin_v[0] = 7'h6E; idle(3); rd(0, 4, 8'h01);
        cur_req = "R6"; rd(0, 4, 8'h00);
        cur_req = "R4";
        pin_v[0] = 7'h4C; idle(3); rd(0, 4, 8'h06);
        cur_req = "R11";
        pin_v[0] = 7'h1C; idle(3); rd(0, 4, 8'h00); rd(0, 1, 8'h1C);
        cur_req = "R3";
        wr(1, 5, 8'h0F);
        pin_v[1] = 7'h07; idle(3); rd(1, 4, 8'h00);
        pin_v[1] = 7'h0F; idle(3); rd(1, 4, 8'h08);
        pin_v[1] = 7'h0B; idle(3); rd(1, 4, 8'h08); rd(1, 4, 8'h00);
        cur_req = "R10"; rd(0, 4, 8'h00); rd(0, 5, 8'h0F);
        cur_req = "R5";
        wr(1, 3, 8'h01);
        pin_v[1] = 7'h29; idle(3); rd(1, 4, 8'h00);
        pin_v[1] = 7'h28; idle(3); rd(1, 4, 8'h01);
        cur_req = "R8";
        wr(1, 5, 8'h00);
        pin_v[1] = 7'h29; idle(3);
        chk(irq_sock[1] == 1'b0, "R8 masked", irq_sock[1], 0);
        wr(1, 5, 8'h01);
        chk(irq_sock[1] == 1'b1 && irq == 1'b1, "R8 enabled", irq_sock[1], 1);
        idle(5);
        chk(irq == 1'b1, "R8 held", irq, 1);
        rd(1, 4, 8'h01);
        chk(irq == 1'b0, "R8 cleared", irq, 0);
        cur_req = "R7";
        pin_v[0] = 7'h1D; cyc(); cyc();
        rd(0, 4, 8'h00); rd(0, 4, 8'h01);
        cur_req = "R10"; rd(1, 4, 8'h00); idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule